// File: doc/BRIEF.md
# CSR Read-Modify-Write Execution Unit

This block carries out the six control-and-status-register instructions for one hardware thread. A decoded 32-bit instruction word and the value of its first source register arrive with a valid strobe. The block picks the operand, which is either the register value or a 5-bit immediate taken from the source-register field. It then reads the addressed CSR and computes the new value. Three operations are supported: swap, bit-set and bit-clear. The read and the write back happen in one indivisible step, and the old value is returned for the destination register.

The CSR storage sits inside the block. It has a parameterised group of read/write registers and a group of read-only registers whose contents are computed from a seed. The read-only registers sit in the part of the 12-bit address space whose top two bits are 11.

Three rules decide which accesses take place:
- A swap whose destination is x0 skips the read.
- A set or clear whose source field is zero skips the write.
- An access to an address that is not implemented raises an illegal flag. So does an issued write to a read-only address. In both cases no state changes.

A two-state machine sequences each instruction:
- **IDLE** accepts work. The transition `accept` happens when a valid CSR instruction is presented; it latches the instruction.
- **EXEC** performs the access. The transition `complete` returns to IDLE after one cycle. On that same edge the registered response is produced.
- A valid word that is not a CSR instruction takes the transition `ignore`: the machine stays in IDLE.

Top module: `csr_exec_unit`

## Requirements
- R1: After reset, done, illegal and rd_we are low and instr_ready is high. Every read/write CSR holds zero.
- R2: An instruction is a CSR instruction when bits 6:0 equal 1110011 and bits 13:12 are nonzero. Bits 14:12 select the operation: 001 is swap, 010 is set and 011 is clear with the register operand; 101, 110 and 111 are the same three with the immediate operand. The address is bits 31:20, the destination index is bits 11:7 and the source field is bits 19:15. Any other valid word is ignored: done never rises and no CSR changes.
- R3: An instruction is accepted on a rising edge where instr_valid and instr_ready are both high. instr_ready is low in the cycle that follows. done, illegal, rd_we, rd_idx and rd_data then hold the result for exactly one cycle, beginning at the second rising edge after acceptance.
- R4: A swap writes the operand into the CSR and returns the previous value.
- R5: A set writes the old value ORed with the operand and returns the previous value.
- R6: A clear writes the old value ANDed with the inverted operand and returns the previous value.
- R7: Immediate forms use the 5-bit source field, zero-extended, as the operand, and ignore rs1_value.
- R8: With destination index 0, rd_we stays low. A swap to x0 still writes the CSR.
- R9: A set or clear whose source field is zero issues no write. It is legal even on a read-only address, and it returns the CSR value.
- R10: An address that is not implemented raises illegal with done. rd_we stays low and no CSR changes.
- R11: An issued write to an address whose bits 11:10 are 11 raises illegal. The register value stays as it was, and rd_we stays low.
- R12: Read-only register i, at address RO_BASE+i, reads RO_SEED+i. With the defaults these are 0xC00 -> 0x5A5A0000 and 0xC01 -> 0x5A5A0001. The read/write registers are at RW_BASE+i, which is 0x340 to 0x343 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word is presented |
| instr | input | 32 | Instruction word |
| rs1_value | input | XLEN | Value of the first source register |
| instr_ready | output | 1 | Block can accept an instruction |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Completed instruction was illegal |
| rd_we | output | 1 | Destination register write enable |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | XLEN | Old CSR value for the destination |

## Verification
The assertions assume that instr and rs1_value are held stable in the cycle of acceptance. They also assume that RO_BASE has its top two bits set to 11 and that RW_BASE does not. The stimulus meets these conditions in two ways. Inputs are driven only on the falling clock edge, and valid is raised only while instr_ready is high. The bench also relies on the default address map. Read-only targets are reached both with a zero source field, which must pass, and with a nonzero source field, which must trap.

// File: rtl/csr_pkg.sv
package csr_pkg;

    localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_SWAP  = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } csr_op_e;

    typedef struct packed {
        csr_op_e     op;
        logic        use_imm;
        logic [11:0] addr;
        logic [4:0]  src_field;
        logic [4:0]  dst;
    } csr_req_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } exec_state_e;

endpackage

// File: rtl/csr_decode.sv
module csr_decode
    import csr_pkg::*;
(
    input  logic [31:0] instr,
    output logic        is_csr,
    output csr_req_t    req
);
    logic [2:0] funct3;
    logic [6:0] opcode;

    always_comb begin
        opcode        = instr[6:0];
        funct3        = instr[14:12];
        req.addr      = instr[31:20];
        req.src_field = instr[19:15];
        req.dst       = instr[11:7];
        req.use_imm   = funct3[2];
        unique case (funct3[1:0])
            2'b01:   req.op = OP_SWAP;
            2'b10:   req.op = OP_SET;
            2'b11:   req.op = OP_CLEAR;
            default: req.op = OP_NONE;
        endcase
        is_csr = (opcode == OPC_SYSTEM) && (funct3[1:0] != 2'b00);
    end
endmodule

// File: rtl/csr_alu.sv
module csr_alu
    import csr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  csr_op_e          op,
    input  logic [XLEN-1:0]  old_val,
    input  logic [XLEN-1:0]  operand,
    output logic [XLEN-1:0]  new_val
);
    always_comb begin
        unique case (op)
            OP_SWAP:  new_val = operand;
            OP_SET:   new_val = old_val | operand;
            OP_CLEAR: new_val = old_val & ~operand;
            default:  new_val = old_val;
        endcase
    end

    // R5 / R6: operand bits end up all set or all cleared
    always_comb begin
        if (op == OP_SET)
            a_r5_set_bits: assert ((new_val & operand) == operand);
        if (op == OP_CLEAR)
            a_r6_clear_bits: assert ((new_val & operand) == '0);
    end
endmodule

// File: rtl/csr_regfile.sv
module csr_regfile #(
    parameter int          XLEN    = 32,
    parameter int          NUM_RW  = 4,
    parameter logic [11:0] RW_BASE = 12'h340,
    parameter int          NUM_RO  = 2,
    parameter logic [11:0] RO_BASE = 12'hC00,
    parameter logic [31:0] RO_SEED = 32'h5A5A_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [11:0]      addr,
    input  logic             rd_en,
    output logic [XLEN-1:0]  rdata,
    output logic             hit,
    input  logic             wr_en,
    input  logic [XLEN-1:0]  wdata
);
    logic [NUM_RW-1:0]     rw_match;
    logic [NUM_RO-1:0]     ro_match;
    logic [XLEN-1:0]       rw_q   [NUM_RW];
    logic [XLEN-1:0]       ro_val [NUM_RO];

    for (genvar gi = 0; gi < NUM_RW; gi++) begin : g_rw
        assign rw_match[gi] = (addr == RW_BASE + 12'(gi));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rw_q[gi] <= '0;
            else if (wr_en && rw_match[gi])
                rw_q[gi] <= wdata;
        end
    end

    for (genvar gj = 0; gj < NUM_RO; gj++) begin : g_ro
        assign ro_match[gj] = (addr == RO_BASE + 12'(gj));
        assign ro_val[gj]   = XLEN'(RO_SEED + 32'(gj));
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            for (int i = 0; i < NUM_RW; i++)
                if (rw_match[i]) rdata = rdata | rw_q[i];
            for (int j = 0; j < NUM_RO; j++)
                if (ro_match[j]) rdata = rdata | ro_val[j];
        end
        hit = (|rw_match) || (|ro_match);
    end

    // R10: storage is only ever written at an implemented address
    a_r10_write_hits: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> hit);
    // R11: no write ever reaches a read-only entry
    a_r11_no_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !(|ro_match));
endmodule

// File: rtl/csr_exec_unit.sv
module csr_exec_unit
    import csr_pkg::*;
#(
    parameter int          XLEN    = 32,
    parameter int          NUM_RW  = 4,
    parameter logic [11:0] RW_BASE = 12'h340,
    parameter int          NUM_RO  = 2,
    parameter logic [11:0] RO_BASE = 12'hC00,
    parameter logic [31:0] RO_SEED = 32'h5A5A_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [31:0]      instr,
    input  logic [XLEN-1:0]  rs1_value,
    output logic             instr_ready,
    output logic             done,
    output logic             illegal,
    output logic             rd_we,
    output logic [4:0]       rd_idx,
    output logic [XLEN-1:0]  rd_data
);
    localparam int IMM_PAD = XLEN - 5;

    exec_state_e      state_q, state_d;
    csr_req_t         dec_req, req_q;
    logic             dec_is_csr;
    logic             accept;
    logic [XLEN-1:0]  operand_q;
    logic [XLEN-1:0]  old_val, new_val;
    logic             do_read, do_write, hit, ro_addr, bad, csr_we;

    csr_decode u_decode (
        .instr  (instr),
        .is_csr (dec_is_csr),
        .req    (dec_req)
    );

    assign instr_ready = (state_q == ST_IDLE);
    assign accept      = instr_valid && instr_ready && dec_is_csr;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q     <= '0;
            operand_q <= '0;
        end else if (accept) begin
            req_q     <= dec_req;
            operand_q <= dec_req.use_imm ? {{IMM_PAD{1'b0}}, dec_req.src_field}
                                         : rs1_value;
        end
    end

    // access rules in the execute cycle
    always_comb begin
        do_read  = !((req_q.op == OP_SWAP) && (req_q.dst == 5'd0));
        do_write = (req_q.op == OP_SWAP) || (req_q.src_field != 5'd0);
        ro_addr  = (req_q.addr[11:10] == 2'b11);
        bad      = !hit || (do_write && ro_addr);
        csr_we   = (state_q == ST_EXEC) && do_write && !bad;
    end

    csr_regfile #(
        .XLEN    (XLEN),
        .NUM_RW  (NUM_RW),
        .RW_BASE (RW_BASE),
        .NUM_RO  (NUM_RO),
        .RO_BASE (RO_BASE),
        .RO_SEED (RO_SEED)
    ) u_regfile (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (req_q.addr),
        .rd_en ((state_q == ST_EXEC) && do_read),
        .rdata (old_val),
        .hit   (hit),
        .wr_en (csr_we),
        .wdata (new_val)
    );

    csr_alu #(.XLEN(XLEN)) u_alu (
        .op      (req_q.op),
        .old_val (old_val),
        .operand (operand_q),
        .new_val (new_val)
    );

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done    <= 1'b0;
            illegal <= 1'b0;
            rd_we   <= 1'b0;
            rd_idx  <= '0;
            rd_data <= '0;
        end else begin
            unique case (state_q)
                ST_EXEC: begin
                    done    <= 1'b1;
                    illegal <= bad;
                    rd_we   <= !bad && (req_q.dst != 5'd0);
                    rd_idx  <= req_q.dst;
                    rd_data <= old_val;
                end
                default: begin
                    done    <= 1'b0;
                    illegal <= 1'b0;
                    rd_we   <= 1'b0;
                end
            endcase
        end
    end

    // R3: response arrives two edges after acceptance
    a_r3_done_timing: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ##2 done);
    // R3: no new acceptance while executing
    a_r3_busy: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !instr_ready);
    // R8: x0 is never written
    a_r8_no_x0: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |-> (rd_idx != 5'd0));
    // R10 / R11: illegal responses never write the destination
    a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && !rd_we));
    // R9: zero source field on set/clear never writes storage
    a_r9_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_EXEC) && (req_q.op != OP_SWAP) && (req_q.src_field == 5'd0))
        |-> !csr_we);
endmodule

// File: tb/csr_exec_unit_bench.sv
`timescale 1ns/1ps
module csr_exec_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs1_value = '0;
    logic        instr_ready, done, illegal, rd_we;
    logic [4:0]  rd_idx;
    logic [31:0] rd_data;

    int checks = 0;
    int failures = 0;
    logic        r_done, r_ill, r_we;
    logic [4:0]  r_idx;
    logic [31:0] r_data;

    localparam logic [2:0] F_RW = 3'b001, F_RS = 3'b010, F_RC = 3'b011;
    localparam logic [2:0] F_RWI = 3'b101, F_RSI = 3'b110, F_RCI = 3'b111;

    always #2.5 clk = ~clk;

    csr_exec_unit u_csr_exec_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .rs1_value(rs1_value), .instr_ready(instr_ready), .done(done),
        .illegal(illegal), .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    function automatic logic [31:0] mk(logic [2:0] f3, logic [11:0] a,
                                       logic [4:0] s, logic [4:0] d);
        return {a, s, f3, d, 7'b1110011};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // issue one instruction and capture the response
    task automatic run(logic [31:0] w, logic [31:0] v);
        @(negedge clk);
        instr = w; rs1_value = v; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        chk("R3 ready low during execute", {31'b0, instr_ready}, 32'd0);
        chk("R3 done not early", {31'b0, done}, 32'd0);
        @(negedge clk);
        r_done = done; r_ill = illegal; r_we = rd_we; r_idx = rd_idx; r_data = rd_data;
        chk("R3 done pulse", {31'b0, r_done}, 32'd1);
        @(negedge clk);
        chk("R3 done one cycle", {31'b0, done}, 32'd0);
    endtask

    task automatic read_csr(string tag, logic [11:0] a, logic [31:0] exp);
        run(mk(F_RS, a, 5'd0, 5'd1), 32'hFFFF_FFFF);
        chk(tag, r_data, exp);
        chk(tag, {31'b0, r_ill}, 32'd0);
    endtask

    task automatic t_reset;
        chk("R1 ready", {31'b0, instr_ready}, 32'd1);
        chk("R1 done", {31'b0, done}, 32'd0);
        chk("R1 illegal", {31'b0, illegal}, 32'd0);
        chk("R1 rd_we", {31'b0, rd_we}, 32'd0);
        for (int i = 0; i < 4; i++) read_csr("R1 csr zero", 12'h340 + 12'(i), 32'd0);
    endtask

    task automatic t_swap;
        run(mk(F_RW, 12'h340, 5'd2, 5'd5), 32'hDEAD_BEEF);
        chk("R4 swap old", r_data, 32'd0);
        chk("R4 swap rd_we", {31'b0, r_we}, 32'd1);
        chk("R4 swap rd_idx", {27'b0, r_idx}, 32'd5);
        read_csr("R4 swap new", 12'h340, 32'hDEAD_BEEF);
    endtask

    task automatic t_set_clear;
        run(mk(F_RS, 12'h340, 5'd3, 5'd6), 32'h0000_00FF);
        chk("R5 set old", r_data, 32'hDEAD_BEEF);
        read_csr("R5 set new", 12'h340, 32'hDEAD_BEFF);
        run(mk(F_RC, 12'h340, 5'd4, 5'd7), 32'hFFFF_0000);
        chk("R6 clear old", r_data, 32'hDEAD_BEFF);
        read_csr("R6 clear new", 12'h340, 32'h0000_BEFF);
    endtask

    task automatic t_imm;
        run(mk(F_RWI, 12'h341, 5'd31, 5'd8), 32'hFFFF_FFFF);
        chk("R7 imm swap old", r_data, 32'd0);
        read_csr("R7 imm zero-extended", 12'h341, 32'h0000_001F);
        run(mk(F_RCI, 12'h341, 5'd3, 5'd9), 32'hFFFF_FFFF);
        read_csr("R7 imm clear", 12'h341, 32'h0000_001C);
        run(mk(F_RSI, 12'h341, 5'd1, 5'd9), 32'h0000_0000);
        read_csr("R7 imm set", 12'h341, 32'h0000_001D);
    endtask

    task automatic t_x0;
        run(mk(F_RW, 12'h342, 5'd1, 5'd0), 32'h0000_1234);
        chk("R8 x0 no rd_we", {31'b0, r_we}, 32'd0);
        chk("R8 x0 legal", {31'b0, r_ill}, 32'd0);
        read_csr("R8 swap to x0 wrote", 12'h342, 32'h0000_1234);
    endtask

    task automatic t_readonly;
        run(mk(F_RS, 12'hC01, 5'd0, 5'd10), 32'hFFFF_FFFF);
        chk("R9 ro read legal", {31'b0, r_ill}, 32'd0);
        chk("R12 ro value 1", r_data, 32'h5A5A_0001);
        run(mk(F_RCI, 12'hC00, 5'd0, 5'd11), 32'h0);
        chk("R9 ro clri zero legal", {31'b0, r_ill}, 32'd0);
        chk("R12 ro value 0", r_data, 32'h5A5A_0000);
        run(mk(F_RS, 12'hC00, 5'd3, 5'd12), 32'h0);
        chk("R11 ro set trap", {31'b0, r_ill}, 32'd1);
        chk("R11 ro no rd_we", {31'b0, r_we}, 32'd0);
        run(mk(F_RWI, 12'hC01, 5'd7, 5'd12), 32'h0);
        chk("R11 ro swap trap", {31'b0, r_ill}, 32'd1);
        read_csr("R11 ro unchanged", 12'hC01, 32'h5A5A_0001);
    endtask

    task automatic t_unimpl;
        run(mk(F_RW, 12'h344, 5'd1, 5'd13), 32'h1111_1111);
        chk("R10 past end trap", {31'b0, r_ill}, 32'd1);
        chk("R10 no rd_we", {31'b0, r_we}, 32'd0);
        run(mk(F_RS, 12'h7FF, 5'd0, 5'd13), 32'h0);
        chk("R10 read trap", {31'b0, r_ill}, 32'd1);
        read_csr("R10 neighbour unchanged", 12'h343, 32'd0);
    endtask

    task automatic t_ignore;
        logic seen;
        seen = 1'b0;
        @(negedge clk);
        instr = {12'h343, 5'd1, 3'b100, 5'd2, 7'b1110011};
        rs1_value = 32'hFFFF_FFFF; instr_valid = 1'b1;
        @(negedge clk);
        instr = {12'h343, 5'd1, F_RW, 5'd2, 7'b0110011};
        @(negedge clk);
        instr_valid = 1'b0;
        chk("R2 still ready", {31'b0, instr_ready}, 32'd1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        chk("R2 ignored no done", {31'b0, seen}, 32'd0);
        read_csr("R2 ignored no write", 12'h343, 32'd0);
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_swap();
        t_set_clear();
        t_imm();
        t_x0();
        t_readonly();
        t_unimpl();
        t_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule